// File: doc/BRIEF.md
# Audio Frame and Bit Clock Generator

This block produces the per-channel frame clock and the serial bit clock for a stereo audio converter. Both come from a single master clock. Every clock is modelled inside one master-clock domain: each output is either a level that changes only on master-clock edges, or a one-cycle enable.

A two-bit speed select sets the frame length in master-clock ticks:

- single speed: 256 ticks
- double speed: 128 ticks
- quad speed: 64 ticks

The bit clock always runs at 64 periods per frame. An optional divide-by-two stage halves the tick rate ahead of everything else, but only when the block is the clock source.

When the block is the clock source it drives both clocks and raises a pad drive-enable. When it is a clock receiver it lowers the drive-enable and forwards the externally supplied clocks. In both roles it produces two one-cycle strobes for the downstream serial data shifter: one at each frame-clock transition and one at the start of each bit period. Any change of configuration restarts the dividers at the beginning of a low frame half.

Top module: `audio_clkgen`

## Requirements
- R1: With `half_rate_i`=1 in source mode, every period and strobe spacing of R2, R3 and R6 doubles, and strobes fire only in the first of each pair of master cycles.
- R2: In source mode, `lrck_o` has a period of 256, 128 or 64 base ticks for `speed_i` = 00, 01 or 10. It is low for the first half of each period.
- R3: In source mode, `sclk_o` has a period of 4, 2 or 1 base ticks for `speed_i` = 00, 01 or 10, which gives 64 bit periods per frame. It is low for the first half of each bit period when that period is at least 2 master cycles.
- R4: In receiver mode (`master_i`=0), `clk_oe_o` is 0, and `lrck_o` and `sclk_o` equal `lrck_i` and `sclk_i` in the same cycle. `half_rate_i` has no effect in this mode.
- R5: `speed_i`=11 is reserved. `config_err_o` is 1 whenever it is applied. In source mode this holds `lrck_o`, `sclk_o` and both strobes at 0.
- R6: `lrck_edge_o` pulses for one cycle at the start of each frame half. `sclk_fall_o` pulses at the start of each bit period. In receiver mode they pulse on the cycle where `lrck_i` differs from its previous-cycle value, and where `sclk_i` is 0 after being 1, respectively.
- R7: In source mode, a change of `master_i`, the effective divide select or `speed_i` forces a one-cycle quiet output. Counting then restarts with `lrck_o` low and both strobes asserted.
- R8: With `speed_i`=10 and `half_rate_i`=0 in source mode, the bit clock equals the master clock. In that case `sclk_o` is held at 1 and `sclk_fall_o` is asserted on every cycle.
- R9: While `rst_ni` is low in source mode, all clock and strobe outputs are 0 and `clk_oe_o` is 1. The first cycle after release is quiet, as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = clock source, 0 = clock receiver |
| half_rate_i | input | 1 | Divide master clock by two (source mode only) |
| speed_i | input | 2 | 00 single, 01 double, 10 quad, 11 reserved |
| lrck_i | input | 1 | External frame clock (receiver mode) |
| sclk_i | input | 1 | External bit clock (receiver mode) |
| lrck_o | output | 1 | Frame clock level |
| sclk_o | output | 1 | Bit clock level |
| clk_oe_o | output | 1 | Pad drive-enable for both clocks |
| lrck_edge_o | output | 1 | One-cycle strobe at each frame-clock transition |
| sclk_fall_o | output | 1 | One-cycle strobe at each bit-period start |
| config_err_o | output | 1 | Reserved speed select applied |

## Verification
Several properties are checked on every cycle:

- receiver-mode pass-through and drive-enable;
- quiet outputs under the reserved speed and during reset;
- every source-mode frame-clock transition carrying a frame strobe, and every frame strobe coinciding with a bit strobe;
- a low frame clock right after a speed change;
- the every-cycle bit strobe at quad speed without the divide.

The exact periods, the duty phase of both clocks, the doubling under the divide select and the cycle on which counting restarts after a mid-frame change can only be shown by the bench. It predicts every output on every cycle from a count of ticks since the last restart.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  localparam int unsigned FRAME_LOG2_MAX = 8;  // longest frame, in base ticks
  localparam int unsigned BITS_LOG2      = 6;  // bit periods per frame

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  typedef struct packed {
    logic   master;
    logic   half_rate;
    speed_e speed;
  } clk_cfg_t;

endpackage

// File: rtl/audio_clk_prediv.sv
module audio_clk_prediv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_o <= 1'b0;
    else if (clr_i)  phase_o <= 1'b0;
    else if (en_i)   phase_o <= ~phase_o;
    else             phase_o <= 1'b0;
  end
endmodule

// File: rtl/audio_frame_cnt.sv
module audio_frame_cnt #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PW    = $clog2(CNT_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [PW-1:0]    len_log2_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] wrap_mask;
  assign wrap_mask = (CNT_W'(1) << len_log2_i) - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (adv_i)  cnt_o <= (cnt_o + CNT_W'(1)) & wrap_mask;
  end
endmodule

// File: rtl/audio_slave_edge.sv
module audio_slave_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  input  logic sclk_i,
  output logic lrck_edge_o,
  output logic sclk_fall_o
);
  logic lrck_q, sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      lrck_q <= lrck_i;
      sclk_q <= sclk_i;
    end
  end

  assign lrck_edge_o = lrck_i ^ lrck_q;
  assign sclk_fall_o = sclk_q & ~sclk_i;
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
  import audio_clkgen_pkg::*;
#(
  parameter int unsigned CNT_W    = FRAME_LOG2_MAX,
  parameter int unsigned BIT_LOG2 = BITS_LOG2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_i,
  input  logic       half_rate_i,
  input  logic [1:0] speed_i,
  input  logic       lrck_i,
  input  logic       sclk_i,
  output logic       lrck_o,
  output logic       sclk_o,
  output logic       clk_oe_o,
  output logic       lrck_edge_o,
  output logic       sclk_fall_o,
  output logic       config_err_o
);
  localparam int unsigned PW = $clog2(CNT_W + 1);

  clk_cfg_t cfg, cfg_q;
  logic     started_q;
  logic     restart, cfg_err, hold;

  assign cfg.master    = master_i;
  assign cfg.half_rate = master_i & half_rate_i;  // divider bypassed as receiver
  assign cfg.speed     = speed_e'(speed_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cfg_q     <= cfg;
      started_q <= 1'b1;
    end
  end

  assign restart = !started_q || (cfg != cfg_q);
  assign cfg_err = (cfg.speed == SPD_RSVD);
  assign hold    = restart | cfg_err | !master_i;

  // base tick prescaler
  logic phase;
  audio_clk_prediv u_prediv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (hold),
    .en_i    (cfg.half_rate),
    .phase_o (phase)
  );

  logic tick_first, tick_last;
  assign tick_first = !cfg.half_rate | !phase;
  assign tick_last  = !cfg.half_rate |  phase;

  logic [PW-1:0] len_log2, bit_log2;
  assign len_log2 = PW'(CNT_W) - PW'(speed_i);
  assign bit_log2 = len_log2 - PW'(BIT_LOG2);

  logic [CNT_W-1:0] cnt;
  audio_frame_cnt #(.CNT_W(CNT_W), .PW(PW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (hold),
    .adv_i      (tick_last),
    .len_log2_i (len_log2),
    .cnt_o      (cnt)
  );

  logic [CNT_W-1:0] half_bit, half_mask, bit_mask, bit_half;
  assign half_bit  = CNT_W'(1) << (len_log2 - PW'(1));
  assign half_mask = half_bit - CNT_W'(1);
  assign bit_mask  = (CNT_W'(1) << bit_log2) - CNT_W'(1);
  assign bit_half  = CNT_W'(1) << (bit_log2 - PW'(1));

  logic lrck_m, sclk_m, edge_m, fall_m;
  assign lrck_m = |(cnt & half_bit);
  assign sclk_m = (bit_log2 == '0) ? (cfg.half_rate ? phase : 1'b1)
                                   : |(cnt & bit_half);
  assign edge_m = tick_first && ((cnt & half_mask) == '0);
  assign fall_m = tick_first && ((cnt & bit_mask) == '0);

  logic rx_edge, rx_fall;
  audio_slave_edge u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lrck_i      (lrck_i),
    .sclk_i      (sclk_i),
    .lrck_edge_o (rx_edge),
    .sclk_fall_o (rx_fall)
  );

  assign lrck_o       = master_i ? (!hold & lrck_m) : lrck_i;
  assign sclk_o       = master_i ? (!hold & sclk_m) : sclk_i;
  assign lrck_edge_o  = master_i ? (!hold & edge_m) : rx_edge;
  assign sclk_fall_o  = master_i ? (!hold & fall_m) : rx_fall;
  assign clk_oe_o     = master_i;
  assign config_err_o = cfg_err;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       master_i,
  input logic       half_rate_i,
  input logic [1:0] speed_i,
  input logic       lrck_i,
  input logic       sclk_i,
  input logic       lrck_o,
  input logic       sclk_o,
  input logic       clk_oe_o,
  input logic       lrck_edge_o,
  input logic       sclk_fall_o,
  input logic       config_err_o,
  input logic       hold_i
);
  p_slave_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (lrck_o == lrck_i && sclk_o == sclk_i && !clk_oe_o));

  p_rsvd_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && config_err_o) |-> (!lrck_o && !sclk_o && !lrck_edge_o && !sclk_fall_o));

  p_edge_marks_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && !hold_i && !$past(hold_i) && lrck_o != $past(lrck_o))
      |-> lrck_edge_o);

  p_frame_on_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && lrck_edge_o) |-> sclk_fall_o);

  p_restart_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && $past(master_i) && speed_i != $past(speed_i)) |=> (!master_i || !lrck_o));

  p_quad_every_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !half_rate_i && speed_i == 2'b10 && !hold_i) |-> (sclk_fall_o && sclk_o));

  always_comb begin
    if (!rst_ni && master_i)
      p_reset_quiet_r9: assert (!lrck_o && !sclk_o && !lrck_edge_o && !sclk_fall_o && clk_oe_o);
  end
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .master_i     (master_i),
  .half_rate_i  (half_rate_i),
  .speed_i      (speed_i),
  .lrck_i       (lrck_i),
  .sclk_i       (sclk_i),
  .lrck_o       (lrck_o),
  .sclk_o       (sclk_o),
  .clk_oe_o     (clk_oe_o),
  .lrck_edge_o  (lrck_edge_o),
  .sclk_fall_o  (sclk_fall_o),
  .config_err_o (config_err_o),
  .hold_i       (hold)
);

// File: tb/audio_clkgen_bench.sv
module audio_clkgen_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       master_i = 1'b1, half_rate_i = 1'b0;
  logic [1:0] speed_i = 2'b00;
  logic       lrck_i = 1'b0, sclk_i = 1'b0;
  logic       lrck_o, sclk_o, clk_oe_o, lrck_edge_o, sclk_fall_o, config_err_o;

  audio_clkgen u_audio_clkgen (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(master_i), .half_rate_i(half_rate_i),
    .speed_i(speed_i), .lrck_i(lrck_i), .sclk_i(sclk_i), .lrck_o(lrck_o),
    .sclk_o(sclk_o), .clk_oe_o(clk_oe_o), .lrck_edge_o(lrck_edge_o),
    .sclk_fall_o(sclk_fall_o), .config_err_o(config_err_o)
  );

  // bench-side configuration
  bit m_v = 1, d_v = 0, rst_v = 0, li_v = 0, si_v = 0, pli = 0, psi = 0;
  int s_v = 0, k = -1;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [5:0] exp_q[$];  // {err, oe, sclk_fall, lrck_edge, sclk, lrck}
  string      tag_q[$];

  function automatic logic [5:0] model(bit m, bit d, int s, int kk, bit li, bit si, bit pl, bit ps);
    int p, sp, b, n;
    bit dd, first, lr, sc, le, sf;
    if (!m) return {s == 3, 1'b0, ps & ~si, li ^ pl, si, li};
    if (s == 3) return 6'b110000;
    if (kk < 0) return 6'b010000;
    p = 256 >> s; sp = 4 >> s; dd = d;
    b = dd ? kk / 2 : kk;
    first = dd ? (kk % 2 == 0) : 1'b1;
    n = b % p;
    lr = (n >= p / 2);
    le = first && (n % (p / 2) == 0);
    sf = first && (n % sp == 0);
    if (sp >= 2) sc = ((n % sp) >= sp / 2);
    else         sc = dd ? (kk % 2 == 1) : 1'b1;
    return {1'b0, 1'b1, sf, le, sc, lr};
  endfunction

  task automatic set_cfg(bit m, bit d, int s);
    if (m != m_v || (m & d) != (m_v & d_v) || s != s_v) k = -1;
    m_v = m; d_v = d; s_v = s;
  endtask

  // driver: drives inputs at negedge and queues the expected outputs
  task automatic step(string tag);
    @(negedge clk);
    rst_ni = rst_v; master_i = m_v; half_rate_i = d_v; speed_i = 2'(s_v);
    lrck_i = li_v; sclk_i = si_v;
    exp_q.push_back(model(m_v, m_v & d_v, s_v, k, li_v, si_v, pli, psi));
    tag_q.push_back(tag);
    pli = li_v; psi = si_v;
    if (rst_v && m_v && s_v != 3) k++;
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor
  always begin
    @(negedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {config_err_o, clk_oe_o, sclk_fall_o, lrck_edge_o, sclk_o, lrck_o};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s t=%0t {err,oe,fall,edge,sclk,lrck} actual=%b expected=%b", t, $time, a, e);
      end
    end
  end

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    run("R9 reset", 5);
    rst_v = 1;
    run("R9 release R2 R3 R6 single", 600);
    set_cfg(1, 0, 1); run("R7 R2 R3 R6 double", 300);
    set_cfg(1, 0, 2); run("R8 quad direct", 200);
    set_cfg(1, 1, 2); run("R1 R3 quad halved", 200);
    set_cfg(1, 1, 0); run("R1 R2 single halved", 1100);
    set_cfg(1, 1, 1); run("R1 R6 double halved", 600);
    set_cfg(1, 0, 0); run("R7 single", 77);
    set_cfg(1, 0, 1); run("R7 mid-frame restart", 300);
    set_cfg(1, 0, 3); run("R5 reserved", 50);
    set_cfg(1, 0, 0); run("R7 leave reserved", 300);
    set_cfg(0, 1, 0);
    for (int j = 0; j < 200; j++) begin
      li_v = j[5]; si_v = j[1];
      step("R4 R6 receiver");
    end
    set_cfg(0, 0, 3);
    for (int j = 0; j < 50; j++) begin
      li_v = j[3]; si_v = j[0];
      step("R4 R5 receiver reserved");
    end
    li_v = 0; si_v = 0;
    set_cfg(1, 1, 2); run("R7 back to source", 100);
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule